// File: doc/BRIEF.md
# Cipher Mode Chaining Controller

This block sits in front of a 128-bit block-cipher engine that can only run in the forward (encrypt) direction. It turns that engine into a stream-style encryptor or decryptor by applying one of two chaining schemes: counter chaining, where a running counter held in the low part of an initial-value register is enciphered and mixed into the data, or full-block cipher feedback, where each enciphered chaining value is mixed into the data and a ciphertext block becomes the next chaining value.

The host loads the chaining register through a load strobe and then offers 128-bit data blocks one at a time on a valid/ready input. For each block the controller sends the chaining register to the cipher engine over a request/response handshake and XORs the engine's answer with the data. It presents the result on a valid/ready output and advances the chaining register in the same cycle that the output is taken. The mode, the direction and the counter width are captured when a block is accepted.

Top module: `chain_ctrl`

## Requirements
- R1: Out of reset the block is idle: `in_ready_o` is 1, `out_valid_o` is 0 and `core_req_valid_o` is 0.
- R2: A cycle with `iv_load_i` high writes `iv_data_i` into the chaining register, drops any block in flight (no output appears for it), returns the block to idle and holds `in_ready_o` low in that cycle. The next block uses the loaded value.
- R3: After a block is accepted, `core_req_valid_o` rises with `core_req_data_o` equal to the chaining register and stays high until `core_req_ready_i` is seen. One response beat on `core_rsp_valid_i` is then awaited.
- R4: `out_data_o` equals the accepted input block XOR the engine's response. It stays stable with `out_valid_o` high until `out_ready_i` is seen.
- R5: In counter mode (`mode_i`=0) the low slice of the chaining register grows by one each time an output is taken. The slice width follows `cw_sel_i`: 0→16, 1→32, 2→64, 3→96, 4→128 bits, and codes 5–7 act as 128.
- R6: The counter slice wraps from all ones to zero. The bits above the slice never change when the counter advances.
- R7: In counter mode, encrypt (`dir_i`=0) and decrypt (`dir_i`=1) give the same output for the same input and chaining value.
- R8: In feedback mode (`mode_i`=1) with `dir_i`=0, the output block becomes the next chaining value.
- R9: In feedback mode with `dir_i`=1, the input block (the received ciphertext) becomes the next chaining value. The engine still only encrypts.
- R10: Only one block is in flight. `in_ready_o` stays low from acceptance until the output has been taken, and back-to-back blocks each use the chaining value left by the previous one.
- R11: `mode_i`, `dir_i` and `cw_sel_i` are sampled when a block is accepted. Changing them while the block is in flight does not affect that block or its chaining update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 counter chaining, 1 cipher feedback |
| dir_i | input | 1 | 0 encrypt, 1 decrypt |
| cw_sel_i | input | 3 | Counter slice width code |
| iv_load_i | input | 1 | Load strobe for the chaining register |
| iv_data_i | input | 128 | Value to load |
| in_valid_i | input | 1 | Input block offered |
| in_ready_o | output | 1 | Input block can be taken |
| in_data_i | input | 128 | Input data block |
| core_req_valid_o | output | 1 | Request to the cipher engine |
| core_req_ready_i | input | 1 | Engine takes the request |
| core_req_data_o | output | 128 | Block to encipher (the chaining value) |
| core_rsp_valid_i | input | 1 | Engine result beat |
| core_rsp_data_i | input | 128 | Engine result |
| out_valid_o | output | 1 | Output block available |
| out_ready_i | input | 1 | Output block taken |
| out_data_o | output | 128 | Output data block |

## Verification
The bench loads counters sitting at all ones for the 16-, 64-, 96- and 128-bit widths. A design that carried out of the slice would corrupt the fixed upper bits, and one that saturated would repeat a counter value. It runs a feedback encryption stream and then decrypts it from the same start value. If the wrong block were fed back on decryption, the plaintext would not come back after the first block. It also changes the mode and width inputs in mid-block and aborts a block with an initial-value load, which catches a design that reads live control inputs or emits an orphan output. Stalled output and engine handshakes show whether the data and the request are held.

// File: rtl/chain_pkg.sv
package chain_pkg;

    localparam int BLK_W = 128;
    localparam int CW_SEL_W = 3;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic { MODE_CTR = 1'b0, MODE_CFB = 1'b1 } mode_e;
    typedef enum logic { DIR_ENC = 1'b0, DIR_DEC = 1'b1 } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_OUT  = 2'd3
    } st_e;

    typedef struct packed {
        mode_e               mode;
        dir_e                dir;
        logic [CW_SEL_W-1:0] cw;
    } cfg_t;

    // number of counter bits for a width code; unknown codes use the full block
    function automatic int cw_bits(input logic [CW_SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 16;
            3'd1:    return 32;
            3'd2:    return 64;
            3'd3:    return 96;
            default: return BLK_W;
        endcase
    endfunction

    function automatic blk_t cw_mask(input logic [CW_SEL_W-1:0] sel);
        blk_t m;
        int   nb;
        nb = cw_bits(sel);
        for (int i = 0; i < BLK_W; i++) begin
            m[i] = (i < nb);
        end
        return m;
    endfunction

    // advance the low slice by one, modulo its width, leaving the upper part alone
    function automatic blk_t ctr_step(input blk_t iv, input logic [CW_SEL_W-1:0] sel);
        blk_t m;
        m = cw_mask(sel);
        return (iv & ~m) | ((iv + blk_t'(1)) & m);
    endfunction

endpackage

// File: rtl/chain_seq.sv
module chain_seq
    import chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic abort_i,
    input  logic in_valid_i,
    input  logic req_ready_i,
    input  logic rsp_valid_i,
    input  logic out_ready_i,
    output logic in_ready_o,
    output logic accept_o,
    output logic req_valid_o,
    output logic capture_o,
    output logic out_valid_o,
    output logic retire_o
);

    st_e st_q, st_d;

    assign in_ready_o  = (st_q == ST_IDLE) && !abort_i;
    assign accept_o    = in_ready_o && in_valid_i;
    assign req_valid_o = (st_q == ST_REQ);
    assign capture_o   = (st_q == ST_WAIT) && rsp_valid_i && !abort_i;
    assign out_valid_o = (st_q == ST_OUT);
    assign retire_o    = (st_q == ST_OUT) && out_ready_i && !abort_i;

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (in_valid_i)  st_d = ST_REQ;
                ST_REQ:  if (req_ready_i) st_d = ST_WAIT;
                ST_WAIT: if (rsp_valid_i) st_d = ST_OUT;
                ST_OUT:  if (out_ready_i) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // R3: request held until the engine takes it
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst || abort_i)
        (req_valid_o && !req_ready_i) |=> req_valid_o);

    // R10: no new input while a result waits
    p_single_block_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> !in_ready_o);

    // R10: acceptance always leads to the engine request next cycle
    p_accept_to_req_r10: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !abort_i) |=> (req_valid_o || abort_i));

endmodule

// File: rtl/chain_hold.sv
module chain_hold
    import chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    input  cfg_t cfg_i,
    input  blk_t din_i,
    input  logic capture_i,
    input  blk_t rsp_i,
    output cfg_t cfg_o,
    output blk_t din_o,
    output blk_t dout_o
);

    cfg_t cfg_q;
    blk_t din_q;
    blk_t dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            din_q  <= '0;
            dout_q <= '0;
        end else begin
            if (accept_i) begin
                cfg_q <= cfg_i;
                din_q <= din_i;
            end
            if (capture_i) begin
                dout_q <= din_q ^ rsp_i;
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign din_o  = din_q;
    assign dout_o = dout_q;

    // R11: captured settings stay put between acceptances
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(cfg_q));

endmodule

// File: rtl/chain_ivreg.sv
module chain_ivreg
    import chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  blk_t load_val_i,
    input  logic retire_i,
    input  cfg_t cfg_i,
    input  blk_t din_i,
    input  blk_t dout_i,
    output blk_t iv_o
);

    blk_t iv_q;
    blk_t iv_next;
    blk_t slice_m;

    assign slice_m = cw_mask(cfg_i.cw);

    always_comb begin
        if (cfg_i.mode == MODE_CTR) begin
            iv_next = ctr_step(iv_q, cfg_i.cw);
        end else if (cfg_i.dir == DIR_ENC) begin
            iv_next = dout_i;
        end else begin
            iv_next = din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q <= '0;
        end else if (load_i) begin
            iv_q <= load_val_i;
        end else if (retire_i) begin
            iv_q <= iv_next;
        end
    end

    assign iv_o = iv_q;

    // R6: bits above the counter slice survive a counter step
    p_fixed_part_r6: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !load_i && cfg_i.mode == MODE_CTR)
        |=> ((iv_q & ~$past(slice_m)) == ($past(iv_q) & ~$past(slice_m))));

    // R2: the register moves only on a load or a retired block
    p_iv_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!retire_i && !load_i) |=> $stable(iv_q));

    // R9: feedback decryption chains the received ciphertext
    p_cfb_dec_r9: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !load_i && cfg_i.mode == MODE_CFB && cfg_i.dir == DIR_DEC)
        |=> (iv_q == $past(din_i)));

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
    import chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              dir_i,
    input  logic [2:0]        cw_sel_i,
    input  logic              iv_load_i,
    input  logic [127:0]      iv_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [127:0]      in_data_i,
    output logic              core_req_valid_o,
    input  logic              core_req_ready_i,
    output logic [127:0]      core_req_data_o,
    input  logic              core_rsp_valid_i,
    input  logic [127:0]      core_rsp_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [127:0]      out_data_o
);

    logic accept;
    logic capture;
    logic retire;
    cfg_t cfg_live;
    cfg_t cfg_blk;
    blk_t din_blk;
    blk_t dout_blk;
    blk_t iv_cur;

    assign cfg_live = '{mode: mode_e'(mode_i), dir: dir_e'(dir_i), cw: cw_sel_i};

    chain_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .abort_i     (iv_load_i),
        .in_valid_i  (in_valid_i),
        .req_ready_i (core_req_ready_i),
        .rsp_valid_i (core_rsp_valid_i),
        .out_ready_i (out_ready_i),
        .in_ready_o  (in_ready_o),
        .accept_o    (accept),
        .req_valid_o (core_req_valid_o),
        .capture_o   (capture),
        .out_valid_o (out_valid_o),
        .retire_o    (retire)
    );

    chain_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .cfg_i     (cfg_live),
        .din_i     (in_data_i),
        .capture_i (capture),
        .rsp_i     (core_rsp_data_i),
        .cfg_o     (cfg_blk),
        .din_o     (din_blk),
        .dout_o    (dout_blk)
    );

    chain_ivreg u_iv (
        .clk        (clk),
        .rst        (rst),
        .load_i     (iv_load_i),
        .load_val_i (iv_data_i),
        .retire_i   (retire),
        .cfg_i      (cfg_blk),
        .din_i      (din_blk),
        .dout_i     (dout_blk),
        .iv_o       (iv_cur)
    );

    assign core_req_data_o = iv_cur;
    assign out_data_o      = dout_blk;

    // R4: result held with valid until taken
    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst || iv_load_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R8: feedback encryption chains the produced ciphertext
    p_cfb_enc_r8: assert property (@(posedge clk) disable iff (rst)
        (retire && !iv_load_i && cfg_blk.mode == MODE_CFB && cfg_blk.dir == DIR_ENC)
        |=> (core_req_data_o == $past(out_data_o)));

    // R3: request carries a value that does not move while it waits
    p_req_data_r3: assert property (@(posedge clk) disable iff (rst || iv_load_i)
        (core_req_valid_o && !core_req_ready_i) |=> $stable(core_req_data_o));

endmodule

// File: tb/chain_ctrl_tb_top.sv
module chain_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] MOCK_KEY = 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_i = 1'b0;
    logic         dir_i = 1'b0;
    logic [2:0]   cw_sel_i = 3'd1;
    logic         iv_load_i = 1'b0;
    logic [127:0] iv_data_i = '0;
    logic         in_valid_i = 1'b0;
    logic         in_ready_o;
    logic [127:0] in_data_i = '0;
    logic         core_req_valid_o;
    logic         core_req_ready_i;
    logic [127:0] core_req_data_o;
    logic         core_rsp_valid_i;
    logic [127:0] core_rsp_data_i;
    logic         out_valid_o;
    logic         out_ready_i = 1'b0;
    logic [127:0] out_data_o;

    int total = 0;
    int bad = 0;

    logic [127:0] iv_m;
    logic [127:0] last_req;
    logic         rdy_q;
    int           req_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_ctrl dut_i (
        .clk              (clk),
        .rst              (rst),
        .mode_i           (mode_i),
        .dir_i            (dir_i),
        .cw_sel_i         (cw_sel_i),
        .iv_load_i        (iv_load_i),
        .iv_data_i        (iv_data_i),
        .in_valid_i       (in_valid_i),
        .in_ready_o       (in_ready_o),
        .in_data_i        (in_data_i),
        .core_req_valid_o (core_req_valid_o),
        .core_req_ready_i (core_req_ready_i),
        .core_req_data_o  (core_req_data_o),
        .core_rsp_valid_i (core_rsp_valid_i),
        .core_rsp_data_i  (core_rsp_data_i),
        .out_valid_o      (out_valid_o),
        .out_ready_i      (out_ready_i),
        .out_data_o       (out_data_o)
    );

    function automatic logic [127:0] mock(input logic [127:0] x);
        return {x[126:0], x[127]} ^ MOCK_KEY;
    endfunction

    function automatic logic [127:0] slice(input logic [2:0] w);
        case (w)
            3'd0:    return {112'b0, {16{1'b1}}};
            3'd1:    return {96'b0, {32{1'b1}}};
            3'd2:    return {64'b0, {64{1'b1}}};
            3'd3:    return {32'b0, {96{1'b1}}};
            default: return {128{1'b1}};
        endcase
    endfunction

    // mock engine: ready toggles to exercise stalls, one response beat later
    always @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            core_rsp_valid_i <= 1'b0;
            core_rsp_data_i <= '0;
        end else begin
            rdy_q <= ~rdy_q;
            core_rsp_valid_i <= 1'b0;
            if (core_req_valid_o && core_req_ready_i) begin
                core_rsp_valid_i <= 1'b1;
                core_rsp_data_i <= mock(core_req_data_o);
                last_req <= core_req_data_o;
                req_cnt <= req_cnt + 1;
            end
        end
    end
    assign core_req_ready_i = rdy_q;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_iv(input logic [127:0] v);
        @(negedge clk);
        iv_data_i = v;
        iv_load_i = 1'b1;
        @(negedge clk);
        iv_load_i = 1'b0;
        iv_m = v;
    endtask

    task automatic do_block(input logic [127:0] din, input logic m, input logic d,
                            input logic [2:0] w, input bit scramble,
                            output logic [127:0] dout);
        logic [127:0] exp_out;
        logic [127:0] first;
        @(negedge clk);
        mode_i = m; dir_i = d; cw_sel_i = w;
        in_data_i = din;
        in_valid_i = 1'b1;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        chk(in_ready_o == 1'b0, "R10 busy after accept", {127'b0, in_ready_o}, 128'd0);
        if (scramble) begin
            mode_i = ~m; dir_i = ~d; cw_sel_i = w ^ 3'd3;
        end
        while (!out_valid_o) @(negedge clk);
        exp_out = din ^ mock(iv_m);
        chk(last_req == iv_m, "R3 engine input", last_req, iv_m);
        chk(out_data_o == exp_out, "R4 output data", out_data_o, exp_out);
        first = out_data_o;
        @(negedge clk);
        chk(out_valid_o && out_data_o == first, "R4 held under stall", out_data_o, first);
        out_ready_i = 1'b1;
        @(negedge clk);
        out_ready_i = 1'b0;
        dout = first;
        if (m == 1'b0)
            iv_m = (iv_m & ~slice(w)) | ((iv_m + 128'd1) & slice(w));
        else if (d == 1'b0)
            iv_m = first;
        else
            iv_m = din;
        mode_i = m; dir_i = d; cw_sel_i = w;
    endtask

    task automatic t_reset;
        chk(in_ready_o == 1'b1, "R1 in_ready", {127'b0, in_ready_o}, 128'd1);
        chk(out_valid_o == 1'b0, "R1 out_valid", {127'b0, out_valid_o}, 128'd0);
        chk(core_req_valid_o == 1'b0, "R1 req_valid", {127'b0, core_req_valid_o}, 128'd0);
    endtask

    task automatic t_ctr_stream;
        logic [127:0] o;
        load_iv(128'h0123_4567_89ab_cdef_0011_2233_ffff_fffe);
        for (int i = 0; i < 4; i++)
            do_block(128'h1000 + 128'(i) * 128'h1_0001, 1'b0, 1'b0, 3'd1, 1'b0, o);
        // counter from ...fffe stepped four times in a 32-bit slice
        chk(iv_m == 128'h0123_4567_89ab_cdef_0011_2233_0000_0002, "R5 step count", iv_m,
            128'h0123_4567_89ab_cdef_0011_2233_0000_0002);
        do_block(128'h5, 1'b0, 1'b0, 3'd1, 1'b0, o);
    endtask

    task automatic t_wrap(input logic [2:0] w, input logic [127:0] start, input logic [127:0] after);
        logic [127:0] o;
        load_iv(start);
        do_block(128'hdead_beef, 1'b0, 1'b0, w, 1'b0, o);
        chk(iv_m == after, "R6 model wrap", iv_m, after);
        do_block(128'h0, 1'b0, 1'b0, w, 1'b0, o);
        chk(last_req == after, "R6 wrapped value sent", last_req, after);
    endtask

    task automatic t_ctr_sym;
        logic [127:0] a;
        logic [127:0] b;
        load_iv(128'h5555_0000_aaaa_0000_1234_0000_0000_0009);
        do_block(128'hfeed_face, 1'b0, 1'b0, 3'd2, 1'b0, a);
        load_iv(128'h5555_0000_aaaa_0000_1234_0000_0000_0009);
        do_block(128'hfeed_face, 1'b0, 1'b1, 3'd2, 1'b0, b);
        chk(a == b, "R7 enc equals dec", b, a);
    endtask

    task automatic t_cfb;
        logic [127:0] p [3];
        logic [127:0] c [3];
        logic [127:0] r;
        p[0] = 128'h1111; p[1] = 128'h2222_0000_0000_0000_0000_0000_0000_0000; p[2] = 128'h3333_3333;
        load_iv(128'hc0ff_ee00_1234_5678_9abc_def0_0f1e_2d3c);
        for (int i = 0; i < 3; i++) begin
            do_block(p[i], 1'b1, 1'b0, 3'd1, 1'b0, c[i]);
            chk(iv_m == c[i], "R8 ciphertext chained", iv_m, c[i]);
        end
        load_iv(128'hc0ff_ee00_1234_5678_9abc_def0_0f1e_2d3c);
        for (int i = 0; i < 3; i++) begin
            do_block(c[i], 1'b1, 1'b1, 3'd1, 1'b0, r);
            chk(r == p[i], "R9 plaintext recovered", r, p[i]);
        end
    endtask

    task automatic t_sampled;
        logic [127:0] o;
        load_iv(128'h7777_0000_0000_0000_0000_0000_0000_00ff);
        do_block(128'habc, 1'b0, 1'b0, 3'd0, 1'b1, o);
        do_block(128'habd, 1'b0, 1'b0, 3'd0, 1'b0, o);
        chk(last_req == 128'h7777_0000_0000_0000_0000_0000_0000_0100, "R11 settings captured",
            last_req, 128'h7777_0000_0000_0000_0000_0000_0000_0100);
    endtask

    task automatic t_abort;
        logic [127:0] o;
        bit seen;
        load_iv(128'h1);
        @(negedge clk);
        mode_i = 1'b0; cw_sel_i = 3'd1;
        in_data_i = 128'h99;
        in_valid_i = 1'b1;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        iv_data_i = 128'h4242_0000;
        iv_load_i = 1'b1;
        chk(in_ready_o == 1'b0, "R2 ready low during load", {127'b0, in_ready_o}, 128'd0);
        @(negedge clk);
        iv_load_i = 1'b0;
        iv_m = 128'h4242_0000;
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (out_valid_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R2 aborted block dropped", {127'b0, seen}, 128'd0);
        chk(in_ready_o == 1'b1, "R2 idle after load", {127'b0, in_ready_o}, 128'd1);
        do_block(128'h77, 1'b0, 1'b0, 3'd1, 1'b0, o);
        chk(last_req == 128'h4242_0000, "R2 loaded value used", last_req, 128'h4242_0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctr_stream();
        t_wrap(3'd0, 128'haaaa_bbbb_cccc_dddd_eeee_ffff_0001_ffff,
                     128'haaaa_bbbb_cccc_dddd_eeee_ffff_0001_0000);
        t_wrap(3'd2, 128'h8000_0000_0000_0001_ffff_ffff_ffff_ffff,
                     128'h8000_0000_0000_0001_0000_0000_0000_0000);
        t_wrap(3'd3, 128'h0000_0003_ffff_ffff_ffff_ffff_ffff_ffff,
                     128'h0000_0003_0000_0000_0000_0000_0000_0000);
        t_wrap(3'd4, {128{1'b1}}, 128'h0);
        t_ctr_sym();
        t_cfb();
        t_sampled();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule